// File: doc/BRIEF.md
# Banked Strided Vector Memory Sequencer

This block runs one strided vector memory operation at a time against an interleaved memory of 16 banks. A start pulse latches a base word address, a signed word stride, a direction (load or store) and an element count. The sequencer then walks the elements in order: element i goes to address base + i*stride, modulo the address space. At most one element is issued per clock. The bank for each element comes from the low address bits. If that bank is still recovering from an earlier access, issue waits, so throughput depends on how the stride spreads the elements over the banks.

Loads come back on a result port a fixed number of cycles after issue, tagged with their element index. Stores take their data from a write-data input, which must hold the word for the element currently shown on the issue port. A one-cycle done pulse marks the end of each operation. The bank storage and its read pipeline are a behavioural model inside the block, sized for the default 256-word address space.

Top module: `vec_mem_seq`

## Requirements
- R1: After reset, `busy`, `iss_fire`, `rd_valid` and `done` are all low, and every bank is free.
- R2: `start` is accepted only while `busy` is low, and `busy` goes high in the next cycle. A `start` pulse seen while `busy` is high changes neither the running operation nor what follows it.
- R3: The element with index i is issued at word address base + i*stride (mod 2^ADDR_W). The stride is treated as a two's-complement word count. Indices are issued in increasing order from 0, at most one per cycle.
- R4: The bank of an address is its low 4 bits. Once a bank accepts an element in cycle c, it can accept another no earlier than cycle c+4.
- R5: When the stride is a multiple of 16, consecutive elements are issued exactly 4 cycles apart.
- R6: With an odd stride, consecutive elements of one operation are issued in back-to-back cycles.
- R7: For a load, `rd_valid` is high exactly 12 cycles after the element's issue cycle. At that point `rd_idx` equals the element index and `rd_data` equals the word stored at that address.
- R8: For a store, the word on `wr_data` in the issue cycle is written to the element's address. When several elements of one store hit the same address, the highest index wins.
- R9: `done` is high for one cycle. For a store it comes one cycle after the last issue. For a load it comes one cycle after the last `rd_valid`. For a count of zero it comes one cycle after the accepted `start`. `busy` is low in the cycle `done` is high.
- R10: A requested count above 64 is clamped to 64 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| is_store | input | 1 | 1 = store, 0 = load; latched at start |
| base | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Signed word distance between elements |
| vlen | input | IDX_W | Requested element count |
| wr_data | input | DATA_W | Store data for the element on `iss_idx` |
| busy | output | 1 | An operation is issuing or draining |
| iss_fire | output | 1 | An element is issued this cycle |
| iss_idx | output | IDX_W | Index of the element at the issue point |
| iss_addr | output | ADDR_W | Word address of the element at the issue point |
| rd_valid | output | 1 | Load result valid |
| rd_idx | output | IDX_W | Element index of the load result |
| rd_data | output | DATA_W | Load result word |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench targets these corner cases:
- Strides that are multiples of 16. An off-by-one recovery counter shows up here as a gap of 3 or 5 cycles instead of 4.
- Odd strides. A design that stalls needlessly on free banks loses the back-to-back issue.
- Negative strides that wrap below address zero. Sign handling errors give wrong addresses.
- Zero-stride stores, where a design that writes out of order leaves the wrong final word.
- Counts of zero and above 64. A wrong clamp issues too many elements. A missing zero case hangs or issues a stray element.
- A `start` pulse injected mid-operation. A design that does not ignore it would restart the address walk.
- Back-to-back operations that hit banks still recovering from the previous one.

// File: rtl/vms_pkg.sv
// Shared types for the vector memory sequencer.
// Assumes nothing beyond a single clock domain.
package vms_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/vms_addr_gen.sv
// Element address walker: holds the current element index and its
// word address, steps both by one element on each issue.
// Assumes 'load' and 'advance' are never high together.
module vms_addr_gen #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic [IDX_W-1:0]  count_in,
    input  logic              advance,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              is_last
);
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [IDX_W-1:0]  count_q;

    // Latch the operation and step index and address per issued element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            addr_q   <= '0;
            stride_q <= '0;
            count_q  <= '0;
        end else if (load) begin
            idx_q    <= '0;
            addr_q   <= base_in;
            stride_q <= stride_in;
            count_q  <= count_in;
        end else if (advance) begin
            idx_q    <= idx_q + 1'b1;
            addr_q   <= addr_q + stride_q;
        end
    end

    // Flag the final element of the operation.
    always_comb begin
        is_last = (idx_q == count_q - 1'b1);
    end

    assign idx  = idx_q;
    assign addr = addr_q;
endmodule

// File: rtl/vms_bank_track.sv
// Per-bank recovery counters. An access to a bank loads its counter
// with BUSY-1; the bank is free when its counter is zero. A bank that
// accepts in cycle c is therefore free again in cycle c+BUSY.
// Assumes at most one access per cycle.
module vms_bank_track #(
    parameter int NBANK = 16,
    parameter int BUSY  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc,
    input  logic [$clog2(NBANK)-1:0] acc_bank,
    output logic [NBANK-1:0]         free
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int CNT_W  = $clog2(BUSY) + 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY - 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;

        // Reload on access, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (acc && acc_bank == BANK_W'(b)) begin
                cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        // A bank is free once its counter has run out.
        assign free[b] = (cnt_q == '0);
    end
endmodule

// File: rtl/vms_bank_mem.sv
// Behavioural interleaved memory: NBANK banks of DATA_W words, bank
// chosen by the low address bits, row by the rest. Reads return
// through a LAT-stage pipeline, so a read issued in cycle c is
// presented in cycle c+LAT together with its element tag.
// Assumes one request per cycle; storage is not reset.
module vms_bank_mem #(
    parameter int NBANK  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 7,
    parameter int LAT    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  tag_idx,
    input  logic              tag_last,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int ROWS   = 1 << ROW_W;

    logic [BANK_W-1:0] bank_sel;
    logic [ROW_W-1:0]  row_sel;
    logic [DATA_W-1:0] bank_rd [NBANK];

    assign bank_sel = addr[BANK_W-1:0];
    assign row_sel  = addr[ADDR_W-1:BANK_W];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] rows_q [ROWS];

        // Write the addressed row when a store targets this bank.
        always_ff @(posedge clk) begin
            if (req && we && bank_sel == BANK_W'(b)) begin
                rows_q[row_sel] <= wdata;
            end
        end

        // Expose the addressed row for reading.
        assign bank_rd[b] = rows_q[row_sel];
    end

    logic [LAT-1:0]    pv_q;
    logic [LAT-1:0]    pl_q;
    logic [IDX_W-1:0]  pi_q [LAT];
    logic [DATA_W-1:0] pd_q [LAT];

    // Shift read-valid and last flags down the latency pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q <= '0;
            pl_q <= '0;
        end else begin
            pv_q <= {pv_q[LAT-2:0], req && !we};
            pl_q <= {pl_q[LAT-2:0], tag_last};
        end
    end

    // Shift read tags and data alongside the valid flags.
    always_ff @(posedge clk) begin
        pi_q[0] <= tag_idx;
        pd_q[0] <= bank_rd[bank_sel];
        for (int k = 1; k < LAT; k++) begin
            pi_q[k] <= pi_q[k-1];
            pd_q[k] <= pd_q[k-1];
        end
    end

    assign out_valid = pv_q[LAT-1];
    assign out_last  = pl_q[LAT-1];
    assign out_idx   = pi_q[LAT-1];
    assign out_data  = pd_q[LAT-1];
endmodule

// File: rtl/vec_mem_seq.sv
// Strided vector memory sequencer over an interleaved bank model.
// Accepts one operation at a time, issues elements in order at most one
// per cycle, stalls while the target bank recovers, and pulses done at
// the end. Assumes wr_data holds the word for iss_idx during a store.
module vec_mem_seq #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64,
    parameter int NBANK  = 16,
    parameter int BUSY   = 4,
    parameter int LAT    = 12,
    parameter int MAXVL  = 64,
    parameter int IDX_W  = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [IDX_W-1:0]  vlen,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              iss_fire,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    import vms_pkg::*;

    localparam int BANK_W = $clog2(NBANK);
    localparam logic [IDX_W-1:0] VL_CAP = IDX_W'(MAXVL);

    seq_state_e        state_q;
    logic              store_q;
    logic [ADDR_W-1:0] stride_q;
    logic              done_q;
    logic              accept;
    logic [IDX_W-1:0]  vlen_eff;
    logic              is_last;
    logic [NBANK-1:0]  bank_free;
    logic [BANK_W-1:0] cur_bank;
    logic              rd_last;

    // Clamp the requested count and qualify start with idle.
    always_comb begin
        vlen_eff = (vlen > VL_CAP) ? VL_CAP : vlen;
        accept   = start && (state_q == ST_IDLE);
    end

    vms_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .base_in   (base),
        .stride_in (stride),
        .count_in  (vlen_eff),
        .advance   (iss_fire),
        .idx       (iss_idx),
        .addr      (iss_addr),
        .is_last   (is_last)
    );

    assign cur_bank = iss_addr[BANK_W-1:0];

    vms_bank_track #(
        .NBANK (NBANK),
        .BUSY  (BUSY)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (iss_fire),
        .acc_bank (cur_bank),
        .free     (bank_free)
    );

    // Issue while sequencing and the target bank has recovered.
    always_comb begin
        iss_fire = (state_q == ST_ISSUE) && bank_free[cur_bank];
    end

    vms_bank_mem #(
        .NBANK  (NBANK),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .LAT    (LAT)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (iss_fire),
        .we        (store_q),
        .addr      (iss_addr),
        .wdata     (wr_data),
        .tag_idx   (iss_idx),
        .tag_last  (is_last && iss_fire && !store_q),
        .out_valid (rd_valid),
        .out_idx   (rd_idx),
        .out_last  (rd_last),
        .out_data  (rd_data)
    );

    // Operation control: idle, issuing elements, draining load returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            store_q  <= 1'b0;
            stride_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        store_q  <= is_store;
                        stride_q <= stride;
                        if (vlen_eff == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (iss_fire && is_last) begin
                        if (store_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (rd_valid && rd_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/vms_checker.sv
// Property checker for vec_mem_seq, attached by bind below.
// Depths 1..3 and 12 follow the default BUSY and LAT values.
module vms_checker #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 7,
    parameter int NBANK  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              iss_fire,
    input logic [IDX_W-1:0]  iss_idx,
    input logic [ADDR_W-1:0] iss_addr,
    input logic              rd_valid,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              done,
    input logic [ADDR_W-1:0] stride_q
);
    localparam int BANK_W = $clog2(NBANK);

    a_r2_no_issue_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !iss_fire);

    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire && $past(iss_fire) |-> iss_idx == $past(iss_idx) + 1'b1);

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire && $past(iss_fire) |-> iss_addr == $past(iss_addr) + stride_q);

    a_r4_gap1: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire && $past(iss_fire, 1) |->
            iss_addr[BANK_W-1:0] != $past(iss_addr[BANK_W-1:0], 1));

    a_r4_gap2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire && $past(iss_fire, 2) |->
            iss_addr[BANK_W-1:0] != $past(iss_addr[BANK_W-1:0], 2));

    a_r4_gap3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire && $past(iss_fire, 3) |->
            iss_addr[BANK_W-1:0] != $past(iss_addr[BANK_W-1:0], 3));

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(iss_fire, 12) && rd_idx == $past(iss_idx, 12));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !$past(done));
endmodule

bind vec_mem_seq vms_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .NBANK  (NBANK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .iss_fire (iss_fire),
    .iss_idx  (iss_idx),
    .iss_addr (iss_addr),
    .rd_valid (rd_valid),
    .rd_idx   (rd_idx),
    .done     (done),
    .stride_q (stride_q)
);

// File: tb/vec_mem_seq_tb.sv
module vec_mem_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_store = 1'b0;
    logic [7:0]  base = '0;
    logic [7:0]  stride = '0;
    logic [6:0]  vlen = '0;
    logic [63:0] wr_data = '0;
    logic        busy, iss_fire, rd_valid, done;
    logic [6:0]  iss_idx, rd_idx;
    logic [7:0]  iss_addr;
    logic [63:0] rd_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [63:0] ref_mem [256];
    int last_b [16];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vec_mem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .base(base), .stride(stride), .vlen(vlen), .wr_data(wr_data),
        .busy(busy), .iss_fire(iss_fire), .iss_idx(iss_idx),
        .iss_addr(iss_addr), .rd_valid(rd_valid), .rd_idx(rd_idx),
        .rd_data(rd_data), .done(done)
    );

    task automatic check(bit ok, string req, string what,
                         logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] elem_addr(logic [7:0] b, logic [7:0] s, int i);
        return b + 8'(i * int'(s));
    endfunction

    // Run one operation and check everything it produces.
    task automatic run_op(bit st, logic [7:0] b, logic [7:0] s,
                          logic [6:0] vl, bit poke);
        int eff = (vl > 64) ? 64 : int'(vl);
        int nexp = 0;
        int nrd = 0;
        int lastrd = -1;
        int t0;
        bit seen = 0;
        bit poked = 0;
        int fc [64];
        logic [63:0] ed [64];
        logic [63:0] sd [64];
        for (int i = 0; i < 64; i++) sd[i] = {$urandom, $urandom};
        @(negedge clk);
        start = 1'b1; is_store = st; base = b; stride = s; vlen = vl;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        check(busy == (eff != 0), "R2", "busy after start", 64'(busy), 64'(eff != 0));
        for (int k = 0; k < 700 && !seen; k++) begin
            wr_data = (iss_idx < 64) ? sd[iss_idx[5:0]] : '0;
            if (poke && !poked && nexp == 3) begin
                start = 1'b1; is_store = ~st; base = b + 8'd77;
                stride = s + 8'd3; vlen = 7'd2; poked = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (iss_fire) begin
                logic [3:0] bk = iss_addr[3:0];
                check(nexp < eff, "R10", "extra element", 64'(nexp), 64'(eff));
                check(iss_idx == 7'(nexp), "R3", "issue index", 64'(iss_idx), 64'(nexp));
                check(iss_addr == elem_addr(b, s, nexp), "R3", "issue address",
                      64'(iss_addr), 64'(elem_addr(b, s, nexp)));
                check(cyc - last_b[bk] >= 4, "R4", "bank reuse gap",
                      64'(cyc - last_b[bk]), 64'd4);
                last_b[bk] = cyc;
                if (nexp > 0 && nexp < 64 && s[3:0] == 4'd0)
                    check(cyc - fc[nexp-1] == 4, "R5", "same-bank spacing",
                          64'(cyc - fc[nexp-1]), 64'd4);
                if (nexp > 0 && nexp < 64 && s[0])
                    check(cyc - fc[nexp-1] == 1, "R6", "odd-stride spacing",
                          64'(cyc - fc[nexp-1]), 64'd1);
                if (nexp < 64) begin
                    fc[nexp] = cyc;
                    if (st) ref_mem[iss_addr] = sd[nexp];
                    else ed[nexp] = ref_mem[iss_addr];
                end
                nexp++;
            end
            if (rd_valid) begin
                check(!st && nrd < eff, "R7", "unexpected read return", 64'(nrd), 64'(eff));
                if (nrd < nexp && nrd < 64) begin
                    check(rd_idx == 7'(nrd), "R7", "return index", 64'(rd_idx), 64'(nrd));
                    check(cyc == fc[nrd] + 12, "R7", "return latency",
                          64'(cyc - fc[nrd]), 64'd12);
                    check(rd_data == ed[nrd], "R7", "return data", rd_data, ed[nrd]);
                end
                lastrd = cyc;
                nrd++;
            end
            if (done) begin
                int expc;
                seen = 1'b1;
                if (eff == 0) expc = t0 + 1;
                else if (st) expc = fc[eff-1] + 1;
                else expc = lastrd + 1;
                check(cyc == expc, "R9", "done timing", 64'(cyc), 64'(expc));
                check(!busy, "R9", "busy with done", 64'(busy), 64'd0);
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(seen, "R9", "done seen", 64'(seen), 64'd1);
        check(nexp == eff, "R10", "element count", 64'(nexp), 64'(eff));
        if (!st) check(nrd == eff, "R7", "return count", 64'(nrd), 64'(eff));
        check(!done, "R9", "done one cycle", 64'(done), 64'd0);
        check(!busy && !iss_fire, "R2", "idle after op (ignored start)",
              64'({busy, iss_fire}), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) last_b[i] = -100;
        repeat (3) @(negedge clk);
        check(!busy && !iss_fire && !rd_valid && !done, "R1", "reset outputs",
              64'({busy, iss_fire, rd_valid, done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !iss_fire && !rd_valid && !done, "R1", "idle after reset",
              64'({busy, iss_fire, rd_valid, done}), 64'd0);
        // Fill all words (R8), then directed corners.
        for (int q = 0; q < 4; q++) run_op(1'b1, 8'(q * 64), 8'd1, 7'd64, 1'b0);
        run_op(1'b0, 8'd0, 8'd1, 7'd64, 1'b0);     // R6, R7 full load
        run_op(1'b0, 8'd2, 8'd16, 7'd8, 1'b0);     // R5 same bank
        run_op(1'b1, 8'd3, 8'd32, 7'd10, 1'b0);    // R5 store
        run_op(1'b0, 8'd3, 8'd32, 7'd10, 1'b0);    // R8 readback
        run_op(1'b0, 8'd5, 8'hff, 7'd20, 1'b0);    // R3 negative wrap
        run_op(1'b1, 8'd9, 8'd0, 7'd6, 1'b0);      // R8 last wins
        run_op(1'b0, 8'd9, 8'd0, 7'd1, 1'b0);
        run_op(1'b0, 8'd4, 8'd1, 7'd0, 1'b0);      // R9 zero count
        run_op(1'b0, 8'd7, 8'd3, 7'd100, 1'b0);    // R10 clamp
        run_op(1'b0, 8'd1, 8'd5, 7'd12, 1'b1);     // R2 ignored start
        run_op(1'b1, 8'd6, 8'd7, 7'd12, 1'b1);
        void'($urandom(32'd1234));
        for (int n = 0; n < 30; n++) begin
            logic [7:0] rs;
            case ($urandom % 4)
                0: rs = 8'($urandom % 8) << 4;
                1: rs = 8'($urandom) | 8'd1;
                2: rs = 8'($urandom % 4);
                default: rs = 8'($urandom);
            endcase
            run_op(1'($urandom), 8'($urandom), rs, 7'($urandom % 81), 1'b0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule